// File: doc/BRIEF.md
# Programmable Galois Pseudo-Random Sequence Generator

This block produces a pseudo-random bit stream from a modular (Galois) linear-feedback shift register. The register length and the feedback taps are not fixed in hardware. Software writes them at run time as a single mask into a polynomial register. The width of the shift register is a whole number of bytes, from 8 to 32 bits, so any length up to that width can run inside it. Stages above the selected length are held at zero.

Software reaches the block through a byte-wide strobe interface with four addresses: shift state, polynomial, seed and control. A seed written while the block is stopped goes straight into the shift state. The shift state can only be read back while the block is stopped, one byte at a time, through a two-step protocol. An external clock-enable input paces the steps while the enable bit is set. The serial output carries the bit shifted out on each step. A one-cycle interrupt marks each return of the state to the seed.

Top module: `prs_gen`

## Requirements
- R1: On a step, the block finds the highest set mask bit n, which gives a length of n+1. The output bit is state[n]. The next state is the state shifted up one place with the output in bit 0. Every bit i>=1 whose mask bit i-1 is set is XORed with the output. Bits above n are cleared. The serial output shows the bit produced by the latest step.
- R2: A mask of 0x30 with a non-zero seed repeats with a period of 63 steps. A mask of 0x8E repeats every 255 steps. A mask of 0x0C repeats every 15 steps.
- R3: A step happens only on a clock where the enable bit is 1 and clk_en_i is 1. Otherwise the shift state holds its value.
- R4: While the enable bit is 0, bit_o and irq_o stay low and the shift state does not advance, whatever clk_en_i does.
- R5: A write to the seed address while disabled sets the seed byte and also copies it into the same byte of the shift state. The same write while enabled changes only the seed register.
- R6: A read of the state address always returns 0. When that read happens while disabled, it also captures the selected state byte. The next read of the polynomial address returns the captured byte and clears the capture, so later polynomial reads return the mask. A state read while enabled captures nothing.
- R7: irq_o is high for one clock each time a step leaves the state equal to the seed, limited to the active length.
- R8: The address map is 0 for state, 1 for polynomial, 2 for seed and 3 for control, with bit 0 of control as the enable. byte_i selects the byte, and byte 0 is the least significant. Read data appears on rdata_o in the clock after rd_i is sampled and holds until the next read.
- R9: After reset, every register is zero, the block is disabled, and bit_o, irq_o and rdata_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Step enable; one step per clock while high and enabled |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address (0 state, 1 polynomial, 2 seed, 3 control) |
| byte_i | input | BSEL_W | Byte index within the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| bit_o | output | 1 | Serial pseudo-random output |
| irq_o | output | 1 | One-cycle pulse when the state returns to the seed |

## Verification
The bench builds the block with two bytes, giving a 16-bit shift register. This brings the byte-select path and the two-step read-back of the upper byte within reach. It also lets every short length run inside a wider register, so the clearing of stages above the length is exercised on every step. The bench sweeps four masks of lengths 4, 6, 8 and 16, several seeds including ones with bits above the length, and step counts from 1 to 40. It compares each read-back state with a step model that follows R1. The 4-, 6- and 8-bit masks run through full periods, with the interrupt spacing and the whole serial stream checked.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    REG_STATE = 2'd0,
    REG_POLY  = 2'd1,
    REG_SEED  = 2'd2,
    REG_CTRL  = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/prs_core.sv
module prs_core #(
  parameter int W      = 8,
  parameter int BSEL_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [BSEL_W-1:0] load_sel_i,
  input  logic [7:0]        load_data_i,
  input  logic [W-1:0]      poly_i,
  input  logic [W-1:0]      seed_i,
  output logic [W-1:0]      state_o,
  output logic [W-1:0]      keep_o,
  output logic              out_o,
  output logic              wrap_o
);
  logic [W-1:0] state_q, state_d;
  logic [W-1:0] keep, top, shifted, fb, stepped, seed_m;
  logic         fb_bit, out_q, wrap_q;

  // keep[i] set when some mask bit at or above i is set: active length
  for (genvar i = 0; i < W; i++) begin : g_keep
    assign keep[i] = |poly_i[W-1:i];
  end

  assign top     = keep & ~(keep >> 1);
  assign fb_bit  = |(state_q & top);
  assign shifted = {state_q[W-2:0], fb_bit};
  assign fb      = {poly_i[W-2:0], 1'b0} & {W{fb_bit}};
  assign stepped = (shifted ^ fb) & keep;
  assign seed_m  = seed_i & keep;

  always_comb begin
    state_d = state_q;
    if (step_i) begin
      state_d = stepped;
    end else if (load_i) begin
      state_d[{load_sel_i, 3'b000} +: 8] = load_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      out_q   <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (!en_i)       out_q <= 1'b0;
      else if (step_i) out_q <= fb_bit;
      wrap_q <= step_i && (stepped == seed_m);
    end
  end

  assign state_o = state_q;
  assign keep_o  = keep;
  assign out_o   = out_q;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/prs_regs.sv
module prs_regs
  import prs_pkg::*;
#(
  parameter int NUM_BYTES = 1,
  parameter int BSEL_W    = 1,
  localparam int W        = 8 * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [BSEL_W-1:0] byte_i,
  input  logic [7:0]        wdata_i,
  input  logic [W-1:0]      state_i,
  output logic              en_o,
  output logic [W-1:0]      poly_o,
  output logic [W-1:0]      seed_o,
  output logic              load_o,
  output logic [7:0]        rdata_o
);
  reg_addr_e  addr;
  logic       en_q, pend_q;
  logic [7:0] hold_q, rdata_q;
  logic [7:0] poly_b [NUM_BYTES];
  logic [7:0] seed_b [NUM_BYTES];
  logic [7:0] state_byte, poly_byte, seed_byte;

  assign addr = reg_addr_e'(addr_i);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        poly_b[b] <= 8'h00;
        seed_b[b] <= 8'h00;
      end else if (wr_i && byte_i == BSEL_W'(b)) begin
        if (addr == REG_POLY) poly_b[b] <= wdata_i;
        if (addr == REG_SEED) seed_b[b] <= wdata_i;
      end
    end
    assign poly_o[b*8 +: 8] = poly_b[b];
    assign seed_o[b*8 +: 8] = seed_b[b];
  end

  assign state_byte = state_i[{byte_i, 3'b000} +: 8];
  assign poly_byte  = poly_o[{byte_i, 3'b000} +: 8];
  assign seed_byte  = seed_o[{byte_i, 3'b000} +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      if (wr_i && addr == REG_CTRL) en_q <= wdata_i[CTRL_EN_BIT];
      if (rd_i) begin
        unique case (addr)
          REG_STATE: begin
            rdata_q <= 8'h00;
            if (!en_q) begin
              hold_q <= state_byte;
              pend_q <= 1'b1;
            end
          end
          REG_POLY: begin
            if (pend_q) begin
              rdata_q <= hold_q;
              pend_q  <= 1'b0;
            end else begin
              rdata_q <= poly_byte;
            end
          end
          REG_SEED: rdata_q <= seed_byte;
          REG_CTRL: rdata_q <= {7'b0, en_q};
          default:  rdata_q <= 8'h00;
        endcase
      end
    end
  end

  assign en_o    = en_q;
  assign load_o  = wr_i && (addr == REG_SEED) && !en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/prs_gen.sv
module prs_gen #(
  parameter int  NUM_BYTES = 1,
  localparam int W         = 8 * NUM_BYTES,
  localparam int BSEL_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [BSEL_W-1:0] byte_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              bit_o,
  output logic              irq_o
);
  logic         en, step, load, out_q, wrap_q;
  logic [W-1:0] poly, seed, state, keep;

  prs_regs #(.NUM_BYTES(NUM_BYTES), .BSEL_W(BSEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .byte_i  (byte_i),
    .wdata_i (wdata_i),
    .state_i (state),
    .en_o    (en),
    .poly_o  (poly),
    .seed_o  (seed),
    .load_o  (load),
    .rdata_o (rdata_o)
  );

  assign step = en && clk_en_i;

  prs_core #(.W(W), .BSEL_W(BSEL_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .step_i      (step),
    .load_i      (load),
    .load_sel_i  (byte_i),
    .load_data_i (wdata_i),
    .poly_i      (poly),
    .seed_i      (seed),
    .state_o     (state),
    .keep_o      (keep),
    .out_o       (out_q),
    .wrap_o      (wrap_q)
  );

  // registered flags may lag a disable by one edge
  assign bit_o = out_q && en;
  assign irq_o = wrap_q && en;
endmodule

// File: rtl/prs_gen_chk.sv
module prs_gen_chk #(
  parameter int W      = 8,
  parameter int BSEL_W = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              step,
  input logic              load,
  input logic [W-1:0]      keep,
  input logic [W-1:0]      state,
  input logic              wr_i,
  input logic              rd_i,
  input logic [1:0]        addr_i,
  input logic [BSEL_W-1:0] byte_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              bit_o,
  input logic              irq_o
);
  p_len_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> ((state & ~$past(keep)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !load) |=> $stable(state));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (!bit_o && !irq_o));

  p_seed_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && !en) |=>
      (state[{$past(byte_i), 3'b000} +: 8] == $past(wdata_i)));

  p_state_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd0) |=> (rdata_o == 8'h00));

  p_irq_after_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(step));
endmodule

bind prs_gen prs_gen_chk #(.W(W), .BSEL_W(BSEL_W)) u_chk (
  .clk_i, .rst_ni, .en, .step, .load, .keep, .state,
  .wr_i, .rd_i, .addr_i, .byte_i, .wdata_i, .rdata_o, .bit_o, .irq_o
);

// File: tb/tb_prs_gen.sv
module tb_prs_gen;
  localparam int NB = 2;
  localparam int W  = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0, clk_en_i = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [0:0] byte_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       bit_o, irq_o;
  int errs = 0, checks = 0;

  always #10 clk_i = ~clk_i;

  prs_gen #(.NUM_BYTES(NB)) dut (
    .clk_i, .rst_ni, .clk_en_i, .wr_i, .rd_i, .addr_i, .byte_i,
    .wdata_i, .rdata_o, .bit_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int top_bit(input logic [W-1:0] p);
    int n = -1;
    for (int i = 0; i < W; i++) if (p[i]) n = i;
    return n;
  endfunction

  function automatic logic [W-1:0] m_step(input logic [W-1:0] s, input logic [W-1:0] p);
    int n = top_bit(p);
    logic o;
    logic [W-1:0] r;
    if (n < 0) return '0;
    o = s[n];
    r = {s[W-2:0], o};
    for (int i = 1; i < W; i++) if (p[i-1] && o) r[i] = ~r[i];
    for (int i = 0; i < W; i++) if (i > n) r[i] = 1'b0;
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic b, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; byte_i = b; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic b, output logic [7:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a; byte_i = b;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic set_poly(input logic [W-1:0] p);
    wr(2'd1, 1'b0, p[7:0]); wr(2'd1, 1'b1, p[15:8]);
  endtask

  task automatic set_seed(input logic [W-1:0] s);
    wr(2'd2, 1'b0, s[7:0]); wr(2'd2, 1'b1, s[15:8]);
  endtask

  task automatic read_state(output logic [W-1:0] s);
    logic [7:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(2'd0, b[0], d);
      chk("R6 state address reads zero", d, 0);
      rd(2'd1, b[0], d);
      s[b*8 +: 8] = d;
    end
  endtask

  task automatic run_steps(input int k);
    @(negedge clk_i); clk_en_i = 1'b1;
    repeat (k) @(negedge clk_i);
    clk_en_i = 1'b0;
  endtask

  task automatic period_test(input logic [W-1:0] p, input int per);
    int first = -1, second = -1, mm = 0, n;
    logic after_first = 1'b1;
    logic [W-1:0] s;
    wr(2'd3, 1'b0, 8'h00);
    set_poly(p);
    set_seed(16'h0001);
    @(negedge clk_i); clk_en_i = 1'b1;
    wr(2'd3, 1'b0, 8'h01);
    for (int c = 0; c < 1000 && second < 0; c++) begin
      @(negedge clk_i);
      if (first >= 0 && c == first + 1) after_first = irq_o;
      if (irq_o) begin
        if (first < 0) first = c;
        else second = c;
      end
    end
    chk("R2 period between irq pulses", second - first, per);
    chk("R7 irq single-cycle", after_first, 1'b0);
    n = top_bit(p);
    s = 16'h0001;
    for (int k = 0; k < per; k++) begin
      @(negedge clk_i);
      if (bit_o !== s[n]) mm++;
      s = m_step(s, p);
    end
    chk("R1 serial stream mismatches", mm, 0);
    chk("R7 irq on return to seed", irq_o, 1'b1);
    clk_en_i = 1'b0;
    wr(2'd3, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0]   d;
    logic [W-1:0] s, e;
    logic [W-1:0] polys [4];
    logic [W-1:0] seeds [3];
    int           ks [3];
    int           bad;
    polys = '{16'h0030, 16'h008E, 16'h000C, 16'hB400};
    seeds = '{16'h0001, 16'h0013, 16'hFFFF};
    ks    = '{1, 7, 40};

    #5;
    chk("R9 bit_o in reset", bit_o, 0);
    chk("R9 irq_o in reset", irq_o, 0);
    chk("R9 rdata_o in reset", rdata_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    rd(2'd1, 1'b0, d); chk("R9 poly reset", d, 0);
    rd(2'd2, 1'b1, d); chk("R9 seed reset", d, 0);
    rd(2'd3, 1'b0, d); chk("R9 ctrl reset", d, 0);
    read_state(s);     chk("R9 state reset", s, 0);

    // R8 byte order and R5 disabled seed load
    set_seed(16'h1234);
    rd(2'd2, 1'b0, d); chk("R8 seed byte0", d, 8'h34);
    rd(2'd2, 1'b1, d); chk("R8 seed byte1", d, 8'h12);
    read_state(s);     chk("R5 disabled seed load", s, 16'h1234);
    set_poly(16'h0030);
    rd(2'd1, 1'b0, d); chk("R6 poly after capture consumed", d, 8'h30);
    wr(2'd3, 1'b0, 8'h01);
    rd(2'd3, 1'b0, d); chk("R8 ctrl enable readback", d, 8'h01);
    wr(2'd3, 1'b0, 8'h00);

    period_test(16'h0030, 63);
    period_test(16'h008E, 255);
    period_test(16'h000C, 15);

    // R1 sweep over masks, seeds and step counts
    foreach (polys[pi]) foreach (seeds[si]) foreach (ks[ki]) begin
      wr(2'd3, 1'b0, 8'h00);
      set_poly(polys[pi]);
      set_seed(seeds[si]);
      wr(2'd3, 1'b0, 8'h01);
      run_steps(ks[ki]);
      wr(2'd3, 1'b0, 8'h00);
      read_state(s);
      e = seeds[si];
      for (int k = 0; k < ks[ki]; k++) e = m_step(e, polys[pi]);
      chk("R1 state after steps", s, e);
    end
    rd(2'd1, 1'b1, d); chk("R6 poly readable after sweep", d, 8'hB4);

    // R4 disabled: clk_en high, no output, state frozen
    set_poly(16'h008E);
    set_seed(16'h00A5);
    bad = 0;
    @(negedge clk_i); clk_en_i = 1'b1;
    repeat (20) begin
      @(negedge clk_i);
      if (bit_o !== 1'b0 || irq_o !== 1'b0) bad++;
    end
    clk_en_i = 1'b0;
    chk("R4 outputs low while disabled", bad, 0);
    read_state(s); chk("R4 state frozen while disabled", s, 16'h00A5);

    // R3 enabled without clk_en: no step
    wr(2'd3, 1'b0, 8'h01);
    bad = 0;
    repeat (20) begin
      @(negedge clk_i);
      if (irq_o !== 1'b0) bad++;
    end
    chk("R3 no irq without clk_en", bad, 0);
    // R5 enabled seed write leaves state
    wr(2'd2, 1'b0, 8'h55);
    // R6 enabled state read captures nothing
    rd(2'd0, 1'b0, d); chk("R6 enabled state read zero", d, 0);
    rd(2'd1, 1'b0, d); chk("R6 enabled read gives poly", d, 8'h8E);
    wr(2'd3, 1'b0, 8'h00);
    read_state(s); chk("R3 R5 state held", s, 16'h00A5);
    rd(2'd2, 1'b0, d); chk("R5 seed stored while enabled", d, 8'h55);

    // R5 byte1 seed into longer mask, then one step
    set_poly(16'hB400);
    wr(2'd2, 1'b1, 8'h80);
    read_state(s); chk("R5 byte1 load", s, 16'h80A5);
    wr(2'd3, 1'b0, 8'h01);
    run_steps(1);
    @(negedge clk_i);
    chk("R1 bit_o after one step", bit_o, 1'b1);
    wr(2'd3, 1'b0, 8'h00);
    read_state(s); chk("R1 16-bit step", s, m_step(16'h80A5, 16'hB400));

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule